// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which older store a newly fetched load or store must wait for. It learns these dependences from ordering violations. Every instruction PC is hashed into a set-membership table, and an entry there holds a valid bit and a set number. A second table is indexed by set number and records the tag of the most recently fetched store of that set. When a load is fetched, the block answers with that tag if one is recorded. When a store is fetched, the block answers the same way, and the store then becomes the recorded store of its set. As a result, stores of one set are chained in fetch order, and a load waits on the last store of its set.

The pipeline reports each violation as a pair of PCs, one for the load and one for the store. Both instructions then join one set. When both already belong to different sets, the two are merged onto the lower set number. Store completion notices remove a recorded store, but only if its tag still occupies the entry. A programmable interval counter wipes both tables at regular intervals, so that aliasing and repeated merging stay bounded. How the pipeline acts on a returned tag is outside this block.

Top module: `mem_dep_predictor`

## Requirements
- R1: After reset both tables are empty and `waitValid` is 0. Any fetch then gets `waitValid` = 0.
- R2: A fetch whose PC has no valid set entry gets `waitValid` = 0. A store fetched this way is not recorded.
- R3: The response is registered. `waitValid`/`waitTag` reflect the fetch presented on the previous rising edge. `waitValid` is 0 in a cycle that follows no fetch.
- R4: A violation in which neither PC has a valid entry places both PCs in one new set. From then on, a fetch of that store is recorded, and a later fetch of that load returns its tag.
- R5: A fetched store with a valid set returns the tag of the previously recorded store of its set, if there is one. It then replaces that record with its own tag, so the next load of the set waits on the newer store.
- R6: A violation in which either entry is valid writes the lower of the valid set numbers to both entries. Set numbers are allocated from a counter that starts at 0 after reset or a clear. Other members of the discarded set keep their old number.
- R7: A completion with tag T invalidates a recorded store only when the recorded tag equals T. A completion with a stale tag leaves the newer record in place.
- R8: When `clearPeriod` is N > 0, every valid bit of both tables is cleared once every N cycles. When N = 1 the clear happens on the next edge. N = 0 disables clearing, and a clear takes priority over a violation in the same cycle.
- R9: When a store fetch and a completion target the same set in one cycle, the new store's record wins.
- R10: The table index is the XOR fold of the PC: index bit j is the XOR of all PC bits i with i mod IDX_W = j. PCs with equal index share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A load or store is fetched this cycle |
| fetchIsStore | input | 1 | 1 for store, 0 for load |
| fetchPc | input | PC_W | PC of the fetched instruction |
| fetchTag | input | TAG_W | In-flight tag of the fetched instruction |
| violValid | input | 1 | Ordering violation reported |
| violLoadPc | input | PC_W | PC of the violating load |
| violStorePc | input | PC_W | PC of the offending store |
| doneValid | input | 1 | A store has completed |
| doneTag | input | TAG_W | Tag of the completed store |
| clearPeriod | input | CLR_W | Cycles between table clears, 0 = never |
| waitValid | output | 1 | Fetched instruction must wait |
| waitTag | output | TAG_W | Tag of the store to wait for |

## Verification
The assertions are checked on every cycle. They cover the following:
- A response only ever follows a fetch.
- After a violation update, the load and the store hold the same set number.
- A merge never picks a number above either valid input.
- The allocation counter steps once per fresh set.
- A clear leaves every valid bit at zero.
- A completion leaves no valid record carrying its tag.

Only the bench scenarios can show the rest, because the table contents are visible only through responses. These are the chaining of stores within a set, the direction of a merge, the stale-completion case, the winner of a same-cycle conflict, aliasing through the hash, and the clear falling inside the programmed window.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef struct packed {
    logic clearAll;
    logic violWr;
    logic lfstWr;
    logic doneWr;
    logic respWr;
  } mdpStrobes_t;

endpackage

// File: rtl/mdp_tables.sv
module mdp_tables
  import mdp_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 6,
  parameter int SET_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdpStrobes_t      strb,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [TAG_W-1:0] fetchTag,
  input  logic [PC_W-1:0]  violLoadPc,
  input  logic [PC_W-1:0]  violStorePc,
  input  logic [TAG_W-1:0] doneTag,
  input  logic [SET_W-1:0] mergeSet,
  output logic             fetchHit,
  output logic             loadEntValid,
  output logic [SET_W-1:0] loadEntSet,
  output logic             storeEntValid,
  output logic [SET_W-1:0] storeEntSet,
  output logic             waitValid,
  output logic [TAG_W-1:0] waitTag
);
  localparam int SSIT_N = 1 << IDX_W;
  localparam int SET_N  = 1 << SET_W;

  function automatic logic [IDX_W-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ pc[i];
    return r;
  endfunction

  logic [SSIT_N-1:0] ssitValid;
  logic [SET_W-1:0]  ssitSet [SSIT_N];
  logic [SET_N-1:0]  lfstValid;
  logic [TAG_W-1:0]  lfstTag [SET_N];

  logic [IDX_W-1:0] fIdx, lIdx, sIdx;
  logic [SET_W-1:0] fetchSet;
  logic [SET_N-1:0] doneMatchVec;

  assign fIdx = foldPc(fetchPc);
  assign lIdx = foldPc(violLoadPc);
  assign sIdx = foldPc(violStorePc);

  assign fetchHit      = ssitValid[fIdx];
  assign fetchSet      = ssitSet[fIdx];
  assign loadEntValid  = ssitValid[lIdx];
  assign loadEntSet    = ssitSet[lIdx];
  assign storeEntValid = ssitValid[sIdx];
  assign storeEntSet   = ssitSet[sIdx];

  always_comb begin
    for (int g = 0; g < SET_N; g++)
      doneMatchVec[g] = lfstValid[g] && (lfstTag[g] == doneTag);
  end

  // set-membership table valid bits
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      ssitValid <= '0;
    end else if (strb.violWr) begin
      ssitValid[lIdx] <= 1'b1;
      ssitValid[sIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.violWr) begin
      ssitSet[lIdx] <= mergeSet;
      ssitSet[sIdx] <= mergeSet;
    end
  end

  // last-store table: a new store record beats a completion on the same set
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      lfstValid <= '0;
    end else begin
      for (int g = 0; g < SET_N; g++) begin
        if (strb.lfstWr && (fetchSet == SET_W'(g))) begin
          lfstValid[g] <= 1'b1;
          lfstTag[g]   <= fetchTag;
        end else if (strb.doneWr && doneMatchVec[g]) begin
          lfstValid[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitValid <= 1'b0;
      waitTag   <= '0;
    end else begin
      waitValid <= strb.respWr && fetchHit && lfstValid[fetchSet];
      waitTag   <= lfstTag[fetchSet];
    end
  end

  p_resp_after_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    waitValid |-> $past(strb.respWr));

  p_viol_joins_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.violWr |=> (ssitValid[$past(lIdx)] && ssitValid[$past(sIdx)] &&
                     ssitSet[$past(lIdx)] == ssitSet[$past(sIdx)]));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (ssitValid == '0 && lfstValid == '0));

  p_done_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doneWr && !strb.clearAll && !strb.lfstWr) |=>
      ((lfstValid & $past(doneMatchVec)) == '0));
endmodule

// File: rtl/mdp_ctrl.sv
module mdp_ctrl
  import mdp_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int CLR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic             fetchIsStore,
  input  logic             fetchHit,
  input  logic             violValid,
  input  logic             loadEntValid,
  input  logic [SET_W-1:0] loadEntSet,
  input  logic             storeEntValid,
  input  logic [SET_W-1:0] storeEntSet,
  input  logic             doneValid,
  input  logic [CLR_W-1:0] clearPeriod,
  output mdpStrobes_t      strb,
  output logic [SET_W-1:0] mergeSet
);
  logic [CLR_W-1:0] clrCount;
  logic [SET_W-1:0] allocId;
  logic             freshSet;
  logic             clearNow;

  assign clearNow = (clearPeriod != '0) &&
                    (({1'b0, clrCount} + 1'b1) >= {1'b0, clearPeriod});
  assign freshSet = !loadEntValid && !storeEntValid;

  always_comb begin
    unique case ({loadEntValid, storeEntValid})
      2'b00:   mergeSet = allocId;
      2'b10:   mergeSet = loadEntSet;
      2'b01:   mergeSet = storeEntSet;
      default: mergeSet = (loadEntSet < storeEntSet) ? loadEntSet : storeEntSet;
    endcase
  end

  always_comb begin
    strb.clearAll = clearNow;
    strb.violWr   = violValid && !clearNow;
    strb.lfstWr   = fetchValid && fetchIsStore && fetchHit;
    strb.doneWr   = doneValid;
    strb.respWr   = fetchValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearNow || clearPeriod == '0) clrCount <= '0;
    else                                          clrCount <= clrCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearNow)             allocId <= '0;
    else if (strb.violWr && freshSet)  allocId <= allocId + 1'b1;
  end

  p_merge_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (violValid && loadEntValid && storeEntValid) |->
      (mergeSet <= loadEntSet && mergeSet <= storeEntSet));

  p_alloc_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.violWr && freshSet) |=> (allocId == $past(allocId) + 1'b1));

  p_clear_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearPeriod == '0) |-> !strb.clearAll);
endmodule

// File: rtl/mem_dep_predictor.sv
module mem_dep_predictor
  import mdp_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 6,
  parameter int SET_W = 4,
  parameter int TAG_W = 6,
  parameter int CLR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic             fetchIsStore,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [TAG_W-1:0] fetchTag,
  input  logic             violValid,
  input  logic [PC_W-1:0]  violLoadPc,
  input  logic [PC_W-1:0]  violStorePc,
  input  logic             doneValid,
  input  logic [TAG_W-1:0] doneTag,
  input  logic [CLR_W-1:0] clearPeriod,
  output logic             waitValid,
  output logic [TAG_W-1:0] waitTag
);
  mdpStrobes_t      strb;
  logic [SET_W-1:0] mergeSet, loadEntSet, storeEntSet;
  logic             fetchHit, loadEntValid, storeEntValid;

  mdp_ctrl #(.SET_W(SET_W), .CLR_W(CLR_W)) uCtrl (
    .clk, .rstN, .fetchValid, .fetchIsStore, .fetchHit, .violValid,
    .loadEntValid, .loadEntSet, .storeEntValid, .storeEntSet,
    .doneValid, .clearPeriod, .strb, .mergeSet
  );

  mdp_tables #(.PC_W(PC_W), .IDX_W(IDX_W), .SET_W(SET_W), .TAG_W(TAG_W)) uTables (
    .clk, .rstN, .strb, .fetchPc, .fetchTag, .violLoadPc, .violStorePc,
    .doneTag, .mergeSet, .fetchHit, .loadEntValid, .loadEntSet,
    .storeEntValid, .storeEntSet, .waitValid, .waitTag
  );
endmodule

// File: tb/tb_mem_dep_predictor.sv
module tb_mem_dep_predictor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0, fetchIsStore = 1'b0;
  logic [15:0] fetchPc = '0;
  logic [5:0]  fetchTag = '0;
  logic        violValid = 1'b0;
  logic [15:0] violLoadPc = '0, violStorePc = '0;
  logic        doneValid = 1'b0;
  logic [5:0]  doneTag = '0;
  logic [15:0] clearPeriod = '0;
  logic        waitValid;
  logic [5:0]  waitTag;
  int checks = 0, failures = 0, cycles = 0;

  localparam logic [15:0] L1 = 16'h0004, S1 = 16'h0008, L2 = 16'h000C;
  localparam logic [15:0] S2 = 16'h0010, L3 = 16'h0014, S3 = 16'h0018;
  localparam logic [15:0] L1ALIAS = 16'h0045; // folds to the same index as L1 (R10)

  always #2 clk = ~clk;

  mem_dep_predictor dut (
    .clk, .rstN, .fetchValid, .fetchIsStore, .fetchPc, .fetchTag,
    .violValid, .violLoadPc, .violStorePc, .doneValid, .doneTag,
    .clearPeriod, .waitValid, .waitTag
  );

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic fetch(input logic st, input logic [15:0] pc, input logic [5:0] tg,
                       input logic ev, input logic [5:0] et, input string rq);
    fetchValid = 1'b1; fetchIsStore = st; fetchPc = pc; fetchTag = tg;
    @(negedge clk);
    fetchValid = 1'b0;
    check(waitValid == ev, {rq, " waitValid"}, int'(waitValid), int'(ev));
    if (ev) check(waitTag == et, {rq, " waitTag"}, int'(waitTag), int'(et));
  endtask

  task automatic viol(input logic [15:0] l, input logic [15:0] s);
    violValid = 1'b1; violLoadPc = l; violStorePc = s;
    @(negedge clk);
    violValid = 1'b0;
  endtask

  task automatic done(input logic [5:0] tg);
    doneValid = 1'b1; doneTag = tg;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic wipe();
    clearPeriod = 16'd1;
    @(negedge clk);
    clearPeriod = 16'd0;
  endtask

  task automatic t_reset();
    check(waitValid == 1'b0, "R1 after reset", int'(waitValid), 0);
    fetch(1'b0, L1, 6'd1, 1'b0, 6'd0, "R1 load after reset");
    fetch(1'b1, S1, 6'd2, 1'b0, 6'd0, "R1 store after reset");
  endtask

  task automatic t_noSet();
    wipe();
    fetch(1'b1, S3, 6'd3, 1'b0, 6'd0, "R2 store without set");
    viol(L3, S3);
    fetch(1'b0, L3, 6'd4, 1'b0, 6'd0, "R2 unlearned store not recorded");
  endtask

  task automatic t_learn();
    wipe();
    viol(L1, S1);
    fetch(1'b0, L1, 6'd1, 1'b0, 6'd0, "R4 empty set no wait");
    fetch(1'b1, S1, 6'd10, 1'b0, 6'd0, "R4 first store");
    fetch(1'b0, L1, 6'd2, 1'b1, 6'd10, "R4 load waits");
    fetch(1'b1, S1, 6'd11, 1'b1, 6'd10, "R5 store chains");
    fetch(1'b0, L1, 6'd3, 1'b1, 6'd11, "R5 load sees newer");
    @(negedge clk);
    check(waitValid == 1'b0, "R3 idle cycle", int'(waitValid), 0);
  endtask

  task automatic t_merge();
    wipe();
    viol(L1, S1); // set 0
    viol(L2, S2); // set 1
    viol(L1, S2); // merge to 0
    fetch(1'b1, S1, 6'd5, 1'b0, 6'd0, "R6 S1 first");
    fetch(1'b1, S2, 6'd6, 1'b1, 6'd5, "R6 S2 moved to lower set");
    fetch(1'b0, L1, 6'd7, 1'b1, 6'd6, "R6 L1 waits on S2");
    fetch(1'b0, L2, 6'd8, 1'b0, 6'd0, "R6 L2 keeps old set");
  endtask

  task automatic t_done();
    wipe();
    viol(L1, S1);
    fetch(1'b1, S1, 6'd20, 1'b0, 6'd0, "R7 store A");
    fetch(1'b1, S1, 6'd21, 1'b1, 6'd20, "R7 store B");
    done(6'd20);
    fetch(1'b0, L1, 6'd1, 1'b1, 6'd21, "R7 stale completion kept");
    done(6'd21);
    fetch(1'b0, L1, 6'd2, 1'b0, 6'd0, "R7 matching completion drops");
  endtask

  task automatic t_sameCycle();
    wipe();
    viol(L1, S1);
    fetch(1'b1, S1, 6'd30, 1'b0, 6'd0, "R9 first store");
    doneValid = 1'b1; doneTag = 6'd30;
    fetch(1'b1, S1, 6'd31, 1'b1, 6'd30, "R9 store with completion");
    doneValid = 1'b0;
    fetch(1'b0, L1, 6'd1, 1'b1, 6'd31, "R9 new record wins");
  endtask

  task automatic t_alias();
    wipe();
    viol(L1, S1);
    fetch(1'b1, S1, 6'd40, 1'b0, 6'd0, "R10 store");
    fetch(1'b0, L1ALIAS, 6'd2, 1'b1, 6'd40, "R10 aliased PC shares entry");
  endtask

  task automatic t_period();
    wipe();
    viol(L1, S1);
    fetch(1'b1, S1, 6'd50, 1'b0, 6'd0, "R8 store");
    violValid = 1'b1; violLoadPc = L2; violStorePc = S2;
    clearPeriod = 16'd1;
    @(negedge clk);
    violValid = 1'b0; clearPeriod = 16'd0;
    fetch(1'b1, S2, 6'd51, 1'b0, 6'd0, "R8 clear beats violation");
    fetch(1'b0, L1, 6'd3, 1'b0, 6'd0, "R8 wipe removes set");
    viol(L1, S1);
    fetch(1'b1, S1, 6'd52, 1'b0, 6'd0, "R8 relearn");
    repeat (100) @(negedge clk);
    fetch(1'b0, L1, 6'd4, 1'b1, 6'd52, "R8 period zero never clears");
    clearPeriod = 16'd30;
    repeat (25) @(negedge clk);
    fetch(1'b0, L1, 6'd5, 1'b1, 6'd52, "R8 before period ends");
    repeat (10) @(negedge clk);
    fetch(1'b0, L1, 6'd6, 1'b0, 6'd0, "R8 after period ends");
    clearPeriod = 16'd0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_noSet();
    t_learn();
    t_merge();
    t_done();
    t_sameCycle();
    t_alias();
    t_period();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule